// File: doc/BRIEF.md
# Bidirectional FIFO Port Access Controller

This block sits on one side of a buffer built from two FIFOs that carry data in opposite directions. It decodes the control lines of one port into the pulses that the rest of the buffer needs. These are a write pulse into the FIFO fed by this port, a read pulse out of the FIFO that this port drains, a pair of mailbox pulses, and an output-enable for the port's shared data bus. The bus is bidirectional and the chip drives it only while the port is being read.

A single pin selects the direction. The two ports of the buffer give opposite meanings to its level, so a parameter fixes the level that means "write", and one module serves either port. Every strobe comes from a flop, so each rising clock edge that qualifies an access produces exactly one cycle of strobe in the following cycle. The data captured from the bus travels with the write strobe. Each port runs on its own clock and shares no state with the other port.

Top module: `pac_port_ctrl`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` is 0 and the direction pin is at its read level; it responds combinationally. `bus_out` carries `mbx_rd_data` while `mbx_sel` is 1 and `fifo_rd_data` otherwise.
- R2: When, at a rising edge, `cs_n`=0, the direction pin is at its write level, `en`=1, `mbx_sel`=0 and `in_rdy`=1, then `fifo_wr_stb` is 1 for the next cycle and `wr_data` holds the value of `bus_in` sampled at that edge.
- R3: When `in_rdy` is 0 at an edge, that edge produces no `fifo_wr_stb`.
- R4: When, at a rising edge, `cs_n`=0, the direction pin is at its read level, `en`=1, `mbx_sel`=0 and `out_rdy`=1, then `fifo_rd_stb` is 1 for the next cycle.
- R5: When `out_rdy` is 0 at an edge, that edge produces no `fifo_rd_stb`.
- R6: With `WR_LEVEL`=1 a high direction pin means write and a low pin means read. With `WR_LEVEL`=0 the meanings are swapped. Apart from that, both settings behave identically.
- R7: When `mbx_sel` is 1, an edge that would otherwise qualify an access produces no FIFO strobe. It produces `mbx_wr_stb` (write level) or `mbx_rd_stb` (read level) instead, whatever the values of `in_rdy` and `out_rdy`.
- R8: An edge at which `cs_n` is 1 or `en` is 0 produces no strobe.
- R9: While `rst_n` is 0, all four strobes are 0, and asserting the reset clears them at once. A strobe lasts one cycle per qualifying edge, so it stays high only while consecutive edges qualify.
- R10: At most one of the four strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Port select, active low |
| wr_rd | input | 1 | Direction pin; write level set by WR_LEVEL |
| en | input | 1 | Access enable, active high |
| mbx_sel | input | 1 | 1 selects mailbox, 0 selects FIFO |
| in_rdy | input | 1 | Input FIFO has room (full flag, active high ready) |
| out_rdy | input | 1 | Output FIFO has data (empty flag, active high ready) |
| bus_in | input | DATA_W | Value received from the data bus pads |
| fifo_rd_data | input | DATA_W | Head word of the output FIFO |
| mbx_rd_data | input | DATA_W | Content of the inbound mailbox |
| fifo_wr_stb | output | 1 | One-cycle write pulse to the input FIFO |
| fifo_rd_stb | output | 1 | One-cycle read pulse to the output FIFO |
| mbx_wr_stb | output | 1 | One-cycle mailbox write pulse |
| mbx_rd_stb | output | 1 | One-cycle mailbox read pulse |
| wr_data | output | DATA_W | Bus word captured with the write pulse |
| bus_oe | output | 1 | Output enable for the data bus pads |
| bus_out | output | DATA_W | Word driven to the pads when enabled |

## Verification
The clocked assertions assume that the control inputs are stable around each rising edge and hold no X after reset. They also assume that the ready flags are the ones the FIFOs present at that edge. The bench changes every input only on the falling edge and releases reset on a falling edge, so every edge samples settled, defined values. Two copies of the block run side by side, one for each `WR_LEVEL` setting, and the bench drives them with complementary direction pins. This shows that the parameter changes nothing but the polarity.

// File: rtl/pac_pkg.sv
`timescale 1ns/1ps
package pac_pkg;
   typedef enum logic [2:0] {
      ACC_IDLE    = 3'd0,
      ACC_FIFO_WR = 3'd1,
      ACC_FIFO_RD = 3'd2,
      ACC_MBX_WR  = 3'd3,
      ACC_MBX_RD  = 3'd4
   } acc_kind_e;

   typedef struct packed {
      logic fifo_wr;
      logic fifo_rd;
      logic mbx_wr;
      logic mbx_rd;
   } strobe_set_t;

   localparam int STROBE_CNT = 4;
endpackage

// File: rtl/pac_dir_decode.sv
`timescale 1ns/1ps
module pac_dir_decode #(
   parameter bit WR_LEVEL = 1'b1
) (
   input  logic wr_rd,
   output logic wr_state,
   output logic rd_state
);
   generate
      if (WR_LEVEL) begin : g_high_writes
         assign wr_state = wr_rd;
         assign rd_state = ~wr_rd;
      end else begin : g_low_writes
         assign wr_state = ~wr_rd;
         assign rd_state = wr_rd;
      end
   endgenerate
endmodule

// File: rtl/pac_access_qual.sv
`timescale 1ns/1ps
module pac_access_qual
   import pac_pkg::*;
(
   input  logic      cs_n,
   input  logic      en,
   input  logic      mbx_sel,
   input  logic      wr_state,
   input  logic      rd_state,
   input  logic      in_rdy,
   input  logic      out_rdy,
   output acc_kind_e acc
);
   logic active;
   assign active = ~cs_n & en;

   always_comb begin
      acc = ACC_IDLE;
      if (active) begin
         if (mbx_sel) begin
            if (wr_state)      acc = ACC_MBX_WR;
            else if (rd_state) acc = ACC_MBX_RD;
         end else begin
            if (wr_state && in_rdy)       acc = ACC_FIFO_WR;
            else if (rd_state && out_rdy) acc = ACC_FIFO_RD;
         end
      end
   end
endmodule

// File: rtl/pac_strobe_reg.sv
`timescale 1ns/1ps
module pac_strobe_reg
   import pac_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         acc,
   input  logic [DATA_W-1:0] bus_in,
   output strobe_set_t       stb,
   output logic [DATA_W-1:0] wr_data
);
   strobe_set_t stb_d;

   always_comb begin
      stb_d         = '0;
      stb_d.fifo_wr = (acc == ACC_FIFO_WR);
      stb_d.fifo_rd = (acc == ACC_FIFO_RD);
      stb_d.mbx_wr  = (acc == ACC_MBX_WR);
      stb_d.mbx_rd  = (acc == ACC_MBX_RD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb <= '0;
      else        stb <= stb_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_data <= '0;
      else if (stb_d.fifo_wr || stb_d.mbx_wr) wr_data <= bus_in;
   end

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb.fifo_wr, stb.fifo_rd, stb.mbx_wr, stb.mbx_rd}))
      else $error("more than one strobe active");
endmodule

// File: rtl/pac_bus_drive.sv
`timescale 1ns/1ps
module pac_bus_drive #(
   parameter int DATA_W = 36
) (
   input  logic              cs_n,
   input  logic              rd_state,
   input  logic              mbx_sel,
   input  logic [DATA_W-1:0] fifo_rd_data,
   input  logic [DATA_W-1:0] mbx_rd_data,
   output logic              bus_oe,
   output logic [DATA_W-1:0] bus_out
);
   assign bus_oe  = ~cs_n & rd_state;
   assign bus_out = mbx_sel ? mbx_rd_data : fifo_rd_data;
endmodule

// File: rtl/pac_port_ctrl.sv
`timescale 1ns/1ps
module pac_port_ctrl
   import pac_pkg::*;
#(
   parameter int DATA_W   = 36,
   parameter bit WR_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_rd,
   input  logic              en,
   input  logic              mbx_sel,
   input  logic              in_rdy,
   input  logic              out_rdy,
   input  logic [DATA_W-1:0] bus_in,
   input  logic [DATA_W-1:0] fifo_rd_data,
   input  logic [DATA_W-1:0] mbx_rd_data,
   output logic              fifo_wr_stb,
   output logic              fifo_rd_stb,
   output logic              mbx_wr_stb,
   output logic              mbx_rd_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              bus_oe,
   output logic [DATA_W-1:0] bus_out
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pac_port_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   logic        wr_state, rd_state;
   acc_kind_e   acc;
   strobe_set_t stb;

   pac_dir_decode #(.WR_LEVEL(WR_LEVEL)) dir_i (
      .wr_rd(wr_rd), .wr_state(wr_state), .rd_state(rd_state));

   pac_access_qual qual_i (
      .cs_n(cs_n), .en(en), .mbx_sel(mbx_sel), .wr_state(wr_state),
      .rd_state(rd_state), .in_rdy(in_rdy), .out_rdy(out_rdy), .acc(acc));

   pac_strobe_reg #(.DATA_W(DATA_W)) stb_i (
      .clk(clk), .rst_n(rst_n), .acc(acc), .bus_in(bus_in),
      .stb(stb), .wr_data(wr_data));

   pac_bus_drive #(.DATA_W(DATA_W)) drv_i (
      .cs_n(cs_n), .rd_state(rd_state), .mbx_sel(mbx_sel),
      .fifo_rd_data(fifo_rd_data), .mbx_rd_data(mbx_rd_data),
      .bus_oe(bus_oe), .bus_out(bus_out));

   assign fifo_wr_stb = stb.fifo_wr;
   assign fifo_rd_stb = stb.fifo_rd;
   assign mbx_wr_stb  = stb.mbx_wr;
   assign mbx_rd_stb  = stb.mbx_rd;

   assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !cs_n) else $error("bus driven while deselected");

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_stb |-> $past(in_rdy)) else $error("write into full FIFO");

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_stb |-> $past(out_rdy)) else $error("read from empty FIFO");

   assert_mbx_blocks_fifo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_stb || fifo_rd_stb) |-> !$past(mbx_sel))
      else $error("FIFO strobe during mailbox select");

   assert_idle_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !en) |=> !(fifo_wr_stb || fifo_rd_stb || mbx_wr_stb || mbx_rd_stb))
      else $error("strobe without select and enable");
endmodule

// File: tb/pac_port_ctrl_tb.sv
`timescale 1ns/1ps
module pac_port_ctrl_tb_top;
   localparam int DW = 36;
   localparam int NV = 14;
   // {cs_n, write_dir, en, mbx, in_rdy, out_rdy, e_fwr, e_frd, e_mwr, e_mrd, e_oe}
   localparam logic [10:0] VEC [NV] = '{
      11'b1_1_1_0_1_1_00000,
      11'b0_1_1_0_1_1_10000,
      11'b0_1_1_0_0_1_00000,
      11'b0_1_0_0_1_1_00000,
      11'b0_0_1_0_1_1_01001,
      11'b0_0_1_0_1_0_00001,
      11'b0_0_0_0_1_1_00001,
      11'b0_1_1_1_1_1_00100,
      11'b0_1_1_1_0_0_00100,
      11'b0_0_1_1_0_0_00011,
      11'b1_0_1_0_1_1_00000,
      11'b0_0_1_1_1_1_00011,
      11'b1_1_1_1_1_1_00000,
      11'b0_1_1_0_1_0_10000
   };
   localparam logic [DW-1:0] FIFO_Q = 36'h9_1234_5678;
   localparam logic [DW-1:0] MBX_Q  = 36'h6_CAFE_0042;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, wdir = 1'b0, en = 1'b0, mbx = 1'b0, in_rdy = 1'b0, out_rdy = 1'b0;
   logic [DW-1:0] bus_in = '0;
   logic a_fwr, a_frd, a_mwr, a_mrd, a_oe, b_fwr, b_frd, b_mwr, b_mrd, b_oe;
   logic [DW-1:0] a_wd, a_out, b_wd, b_out;
   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   pac_port_ctrl #(.DATA_W(DW), .WR_LEVEL(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wdir), .en(en), .mbx_sel(mbx),
      .in_rdy(in_rdy), .out_rdy(out_rdy), .bus_in(bus_in), .fifo_rd_data(FIFO_Q),
      .mbx_rd_data(MBX_Q), .fifo_wr_stb(a_fwr), .fifo_rd_stb(a_frd), .mbx_wr_stb(a_mwr),
      .mbx_rd_stb(a_mrd), .wr_data(a_wd), .bus_oe(a_oe), .bus_out(a_out));

   pac_port_ctrl #(.DATA_W(DW), .WR_LEVEL(1'b0)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(~wdir), .en(en), .mbx_sel(mbx),
      .in_rdy(in_rdy), .out_rdy(out_rdy), .bus_in(bus_in), .fifo_rd_data(FIFO_Q),
      .mbx_rd_data(MBX_Q), .fifo_wr_stb(b_fwr), .fifo_rd_stb(b_frd), .mbx_wr_stb(b_mwr),
      .mbx_rd_stb(b_mrd), .wr_data(b_wd), .bus_oe(b_oe), .bus_out(b_out));

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [10:0] v);
      if (v[10] || !v[8])        return "R8";
      else if (v[7])             return "R7";
      else if (v[9])             return v[6] ? "R2" : "R3";
      else                       return v[5] ? "R4" : "R5";
   endfunction

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // reset state with a qualifying write held on the inputs: R9
      cs_n = 0; wdir = 1; en = 1; in_rdy = 1; out_rdy = 1; bus_in = 36'h1;
      repeat (3) @(posedge clk);
      #2 chk("R9 reset strobes", {a_fwr, a_frd, a_mwr, a_mrd}, '0);
      chk("R9 reset strobes B", {b_fwr, b_frd, b_mwr, b_mrd}, '0);
      @(negedge clk); rst_n = 1; cs_n = 1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {cs_n, wdir, en, mbx, in_rdy, out_rdy} = VEC[i][10:5];
         bus_in = 36'hA_0000_0000 + DW'(i);
         #2;
         chk("R1 oe", a_oe, VEC[i][0]);
         chk("R6 oe port B", b_oe, VEC[i][0]);
         chk("R1 bus_out", a_out, mbx ? MBX_Q : FIFO_Q);
         @(posedge clk); #2;
         chk(tag_of(VEC[i]), {a_fwr, a_frd, a_mwr, a_mrd}, DW'(VEC[i][4:1]));
         chk("R6 strobes port B", {b_fwr, b_frd, b_mwr, b_mrd}, DW'(VEC[i][4:1]));
         chk("R10 single strobe", DW'($countones({a_fwr, a_frd, a_mwr, a_mrd}) <= 1), 1);
         if (VEC[i][4] || VEC[i][2]) begin
            chk("R2 wr_data", a_wd, 36'hA_0000_0000 + DW'(i));
            chk("R6 wr_data port B", b_wd, 36'hA_0000_0000 + DW'(i));
         end
      end

      // consecutive qualifying edges then release: R9 pulse per edge, R2 data
      @(negedge clk);
      {cs_n, wdir, en, mbx, in_rdy, out_rdy} = 6'b0_1_1_0_1_0; bus_in = 36'h111;
      @(posedge clk); #2 chk("R2 back-to-back 1", a_fwr, 1);
      @(negedge clk); bus_in = 36'h222;
      @(posedge clk); #2 chk("R2 back-to-back 2", a_fwr, 1);
      chk("R2 back-to-back data", a_wd, 36'h222);
      @(negedge clk); en = 0; bus_in = 36'h333;
      @(posedge clk); #2 chk("R9 pulse ends", a_fwr, 0);
      chk("R8 data held when idle", a_wd, 36'h222);

      // asynchronous reset clears an active strobe: R9
      @(negedge clk); wdir = 0; en = 1; out_rdy = 1;
      @(posedge clk); #2 chk("R4 read before reset", a_frd, 1);
      @(negedge clk); rst_n = 0;
      #1 chk("R9 async clear", {a_fwr, a_frd, a_mwr, a_mrd}, '0);
      chk("R9 async clear B", {b_fwr, b_frd, b_mwr, b_mrd}, '0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule